// File: doc/BRIEF.md
# CIC Interpolation Upsampler

This block raises the sample rate of a signed parallel audio stream by a factor that can be chosen at run time: 125, 128 or 136. Four comb sections run once per input sample, each with a differential delay of one. Their result is zero-stuffed up to the output rate and then passed through four cascaded integrators. These run once per oversampled clock-enable tick. Because of the gain normalisation, a constant input gives the same constant at the output. The response is sinc shaped, with its first null at the input rate. Images of the baseband are therefore attenuated but not removed, and a linear-phase passband compensation stage is expected to follow the block.

Samples enter through a valid/ready handshake at the base rate. One output sample is produced on every enabled tick. The rate select is captured while the block is disabled and must be settled before enable rises. Dropping the enable wipes every piece of internal state.

Top module: `cic_interp`

## Requirements
- R1: After reset, `out_data` is 0 and `out_valid` and `in_ready` are low.
- R2: `in_ready` is high only in a cycle where `en` and `tick` are both high and the phase counter is zero. This happens on the first enabled tick and then on every R-th enabled tick. R is taken from the captured select: 2'b00 gives 128, 2'b01 gives 125, 2'b10 gives 136 and 2'b11 gives 128.
- R3: The select is captured on every clock edge where `en` is low. A change of `rate_sel` while `en` is high has no effect on R.
- R4: On a tick with `in_ready` high, the sample taken is `in_data` if `in_valid` is high and zero otherwise. That sample passes through four comb stages (y = x − previous x). The comb result is injected into the integrator cascade on that tick, and zero is injected on every other tick. Each of the four integrators adds its predecessor's new value. The output register loads the scaled last-integrator value at the edge that ends the tick.
- R5: The output is (A·K + 2^39) >>> 40, where A is the last integrator value and K = round(2^40 / R^3). A steady input therefore gives an output within 1 LSB of the input.
- R6: In an enabled cycle without a tick, `out_data` keeps its value.
- R7: At every edge where `en` is low, all comb, integrator and phase state is cleared, and `out_data` becomes 0 with `out_valid` low. After re-enable the block starts from clean state.
- R8: `out_valid` is high for exactly the cycle that follows each enabled tick edge, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears all state |
| rate_sel | input | 2 | Upsampling ratio select, captured while disabled |
| tick | input | 1 | Oversampled-rate clock enable |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Sample accepted in this cycle |
| in_data | input | IW | Signed input sample |
| out_valid | output | 1 | New output sample present |
| out_data | output | IW | Signed interpolated sample |

## Verification
On the phase-zero tick two things happen in the same clock. The comb bank takes in a new sample and injects its difference, and that same difference is added through all four integrators into the output register. The bench provokes this with ticks on every cycle, so accepting ticks fall back to back with pure integration ticks. It also runs with ticks spaced by idle cycles and with samples whose valid is dropped. Every output word is judged against a reference model of the cascade and the scaling formula, which the bench computes itself. Steady inputs at full scale are also checked against the 1-LSB unity bound.

// File: rtl/cic_interp_pkg.sv
package cic_interp_pkg;

    localparam int unsigned RATE_MIN = 125;
    localparam int unsigned RATE_MAX = 136;

    typedef enum logic [1:0] {
        SEL_X128 = 2'b00,
        SEL_X125 = 2'b01,
        SEL_X136 = 2'b10,
        SEL_ALT  = 2'b11
    } rate_sel_e;

    // Upsampling factor for a select code; the spare code falls back to 128.
    function automatic int unsigned rate_of(input logic [1:0] s);
        case (s)
            2'b01:   return 125;
            2'b10:   return 136;
            default: return 128;
        endcase
    endfunction

    // round(2^sh / r^(n-1)): multiplier that removes the cascade gain.
    function automatic longint unsigned norm_gain(input int unsigned r,
                                                  input int unsigned n,
                                                  input int unsigned sh);
        longint unsigned g;
        g = 64'd1;
        for (int i = 1; i < int'(n); i++) g = g * 64'(r);
        return ((64'd1 << sh) + g / 2) / g;
    endfunction

endpackage

// File: rtl/cic_rate_ctl.sv
module cic_rate_ctl
    import cic_interp_pkg::*;
#(
    parameter int unsigned PHW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic [1:0] rate_sel,
    output logic       accept,
    output rate_sel_e  sel_lat
);

    typedef struct packed {
        logic [PHW-1:0] ph;
        rate_sel_e      sel;
    } ctl_t;

    ctl_t           st_d, st_q;
    logic [PHW-1:0] last_ph;

    always_comb begin
        st_d    = st_q;
        last_ph = PHW'(rate_of(st_q.sel) - 1);
        if (!en) begin
            st_d.ph  = '0;
            st_d.sel = rate_sel_e'(rate_sel);
        end else if (tick) begin
            st_d.ph = (st_q.ph == last_ph) ? '0 : st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= '0;
            st_q.sel <= SEL_X128;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept  = en && tick && (st_q.ph == '0);
    assign sel_lat = st_q.sel;

endmodule

// File: rtl/cic_comb_bank.sv
module cic_comb_bank #(
    parameter int unsigned IW = 16,
    parameter int unsigned AW = 48,
    parameter int unsigned N  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 load,
    input  logic signed [IW-1:0] x,
    output logic signed [AW-1:0] y
);

    typedef struct packed {
        logic [N-1:0][AW-1:0] dly;
    } comb_t;

    comb_t              st_d, st_q;
    logic signed [AW-1:0] tap [N+1];

    assign tap[0] = AW'(x);

    for (genvar k = 0; k < N; k++) begin : g_stage
        assign tap[k+1] = tap[k] - $signed(st_q.dly[k]);
    end

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (load) begin
            for (int k = 0; k < int'(N); k++) st_d.dly[k] = tap[k];
        end
        // zero stuffing: only the accepting tick carries a value
        y = load ? tap[N] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/cic_integ_bank.sv
module cic_integ_bank #(
    parameter int unsigned AW = 48,
    parameter int unsigned N  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 step,
    input  logic signed [AW-1:0] u,
    output logic signed [AW-1:0] acc
);

    typedef struct packed {
        logic [N-1:0][AW-1:0] acc;
    } integ_t;

    integ_t             st_d, st_q;
    logic signed [AW-1:0] sum [N+1];

    assign sum[0] = u;

    for (genvar k = 0; k < N; k++) begin : g_stage
        assign sum[k+1] = $signed(st_q.acc[k]) + sum[k];
    end

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (step) begin
            for (int k = 0; k < int'(N); k++) st_d.acc[k] = sum[k+1];
        end
        acc = sum[N];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/cic_gain_norm.sv
module cic_gain_norm #(
    parameter int unsigned AW    = 48,
    parameter int unsigned KW    = 23,
    parameter int unsigned OW    = 16,
    parameter int unsigned SHIFT = 40
) (
    input  logic signed [AW-1:0] acc,
    input  logic        [KW-1:0] gain,
    output logic signed [OW-1:0] y
);

    localparam int unsigned PW = AW + KW + 1;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (SHIFT - 1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rounded;

    always_comb begin
        prod    = PW'(acc) * $signed(PW'({1'b0, gain}));
        rounded = prod + HALF;
        y       = OW'(rounded >>> SHIFT);
    end

endmodule

// File: rtl/cic_interp.sv
module cic_interp
    import cic_interp_pkg::*;
#(
    parameter int unsigned IW     = 16,
    parameter int unsigned STAGES = 4,
    parameter int unsigned SHIFT  = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [1:0]           rate_sel,
    input  logic                 tick,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [IW-1:0] in_data,
    output logic                 out_valid,
    output logic signed [IW-1:0] out_data
);

    localparam int unsigned PHW   = $clog2(RATE_MAX);
    localparam int unsigned GUARD = STAGES * $clog2(RATE_MAX);
    localparam int unsigned AW    = IW + GUARD;
    localparam int unsigned KW    = SHIFT - (STAGES - 1) * ($clog2(RATE_MIN) - 1) + 1;

    localparam logic [KW-1:0] K_125 = KW'(norm_gain(125, STAGES, SHIFT));
    localparam logic [KW-1:0] K_128 = KW'(norm_gain(128, STAGES, SHIFT));
    localparam logic [KW-1:0] K_136 = KW'(norm_gain(136, STAGES, SHIFT));

    typedef struct packed {
        logic          vld;
        logic [IW-1:0] data;
    } out_t;

    logic                 accept;
    rate_sel_e            sel_lat;
    logic signed [IW-1:0] sample;
    logic signed [AW-1:0] stuffed;
    logic signed [AW-1:0] acc_nx;
    logic signed [IW-1:0] scaled;
    logic        [KW-1:0] gain;
    logic                 step;
    out_t                 out_d, out_q;

    cic_rate_ctl #(.PHW(PHW)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (tick),
        .rate_sel (rate_sel),
        .accept   (accept),
        .sel_lat  (sel_lat)
    );

    assign sample = in_valid ? in_data : '0;
    assign step   = en && tick;

    cic_comb_bank #(.IW(IW), .AW(AW), .N(STAGES)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .load  (accept),
        .x     (sample),
        .y     (stuffed)
    );

    cic_integ_bank #(.AW(AW), .N(STAGES)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .step  (step),
        .u     (stuffed),
        .acc   (acc_nx)
    );

    always_comb begin
        case (sel_lat)
            SEL_X125: gain = K_125;
            SEL_X136: gain = K_136;
            default:  gain = K_128;
        endcase
    end

    cic_gain_norm #(.AW(AW), .KW(KW), .OW(IW), .SHIFT(SHIFT)) u_norm (
        .acc  (acc_nx),
        .gain (gain),
        .y    (scaled)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = step;
        if (!en)       out_d.data = '0;
        else if (tick) out_d.data = scaled;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign in_ready  = accept;
    assign out_valid = out_q.vld;
    assign out_data  = out_q.data;

endmodule

// File: rtl/cic_interp_chk.sv
module cic_interp_chk
    import cic_interp_pkg::*;
#(
    parameter int unsigned OW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          tick,
    input logic          in_ready,
    input logic          out_valid,
    input logic [OW-1:0] out_data,
    input logic [1:0]    sel_lat
);

    logic [7:0] cnt_q;
    logic       have_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            have_q <= 1'b0;
        end else if (!en) begin
            cnt_q  <= '0;
            have_q <= 1'b0;
        end else if (in_ready) begin
            cnt_q  <= 8'd1;
            have_q <= 1'b1;
        end else if (tick) begin
            cnt_q  <= cnt_q + 8'd1;
        end
    end

    // R2
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (en && tick));

    // R2
    ready_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && have_q) |-> (cnt_q == 8'(rate_of(sel_lat))));

    // R6
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(out_data));

    // R7
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (out_data == '0 && !out_valid));

    // R8
    valid_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick) |=> out_valid);

    // R8
    valid_only_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && tick) |=> !out_valid);

endmodule

bind cic_interp cic_interp_chk #(.OW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .tick      (tick),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .sel_lat   (sel_lat)
);

// File: tb/cic_interp_test.sv
module cic_interp_test;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               en;
    logic [1:0]         rate_sel;
    logic               tick;
    logic               in_valid;
    logic               in_ready;
    logic signed [15:0] in_data;
    logic               out_valid;
    logic signed [15:0] out_data;

    always #10 clk = ~clk;

    cic_interp uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .rate_sel  (rate_sel),
        .tick      (tick),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int      n_chk = 0;
    int      n_fail = 0;
    bit      done = 0;
    longint  exp_q[$];

    // reference model state
    longint     m_c[4];
    longint     m_g[4];
    int         m_ph;
    logic [1:0] m_sel;
    longint     m_hold;
    int         tick_idx;
    int         last_rdy;
    bit         have_rdy;

    function automatic int rat(input logic [1:0] s);
        if (s == 2'b01) return 125;
        if (s == 2'b10) return 136;
        return 128;
    endfunction

    function automatic longint kof(input int r);
        longint r3;
        r3 = longint'(r) * longint'(r) * longint'(r);
        return ((64'sd1 <<< 40) + r3 / 2) / r3;
    endfunction

    function automatic longint scale(input longint a, input int r);
        longint p;
        p = a * kof(r);
        return (p + (64'sd1 <<< 39)) >>> 40;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 4; k++) begin
            m_c[k] = 0;
            m_g[k] = 0;
        end
        m_ph     = 0;
        m_hold   = 0;
        tick_idx = 0;
        have_rdy = 0;
    endtask

    // driver side of the scoreboard: predicts the tick's output, queues it
    task automatic model_tick(input logic v, input logic signed [15:0] d);
        longint u;
        u = 0;
        if (m_ph == 0) begin
            u = v ? longint'(d) : 0;
            for (int k = 0; k < 4; k++) begin
                longint t;
                t = u - m_c[k];
                m_c[k] = u;
                u = t;
            end
        end
        m_g[0] += u;
        m_g[1] += m_g[0];
        m_g[2] += m_g[1];
        m_g[3] += m_g[2];
        m_hold = scale(m_g[3], rat(m_sel));
        exp_q.push_back(m_hold);
        m_ph = (m_ph == rat(m_sel) - 1) ? 0 : m_ph + 1;
    endtask

    task automatic step(input bit e, input bit tk, input bit v,
                        input logic signed [15:0] d, input logic [1:0] rs);
        bit exp_rdy;
        @(negedge clk);
        en       = e;
        tick     = tk;
        in_valid = v;
        in_data  = d;
        rate_sel = rs;
        #1;
        exp_rdy = e && tk && (m_ph == 0);
        // R2: ready only on the phase-zero enabled tick
        chk(in_ready == exp_rdy, "R2", longint'(in_ready), longint'(exp_rdy));
        if (e && tk && in_ready) begin
            if (have_rdy)
                chk(tick_idx - last_rdy == rat(m_sel), (rs != m_sel) ? "R3" : "R2",
                    tick_idx - last_rdy, rat(m_sel));
            have_rdy = 1;
            last_rdy = tick_idx;
        end
        if (!e) begin
            model_clear();
            m_sel = rs;
        end else if (tk) begin
            model_tick(v, d);
            tick_idx++;
        end
        @(posedge clk);
        #1;
        if (!e) begin
            // R7
            chk(out_data == 0, "R7", longint'(out_data), 0);
            chk(out_valid == 1'b0, "R7", longint'(out_valid), 0);
        end else if (tk) begin
            chk(out_valid == 1'b1, "R8", longint'(out_valid), 1);
        end else begin
            chk(out_valid == 1'b0, "R8", longint'(out_valid), 0);
            chk(longint'(out_data) == m_hold, "R6", longint'(out_data), m_hold);
        end
    endtask

    task automatic run(input int nt, input int gap, input logic [1:0] rs,
                       input int kind, input int base);
        for (int i = 0; i < nt; i++) begin
            for (int j = 1; j < gap; j++) step(1, 0, 1, 16'(base), rs);
            if (kind == 0) step(1, 1, 1, 16'(base), rs);
            else           step(1, 1, (i % 5) != 3, 16'(base + (i * 37) % 1000 - 500), rs);
        end
    endtask

    task automatic dc_chk(input int v);
        longint diff;
        diff = longint'(out_data) - longint'(v);
        if (diff < 0) diff = -diff;
        // R5: unity DC gain within one LSB
        chk(diff <= 1, "R5", longint'(out_data), longint'(v));
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8", 1, 0);
            end else begin
                longint e;
                e = exp_q.pop_front();
                // R4 R5: cascade output scaled by the per-ratio constant
                chk(longint'(out_data) == e, "R4", longint'(out_data), e);
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        en       = 1'b0;
        rate_sel = 2'b00;
        tick     = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        m_sel    = 2'b00;
        last_rdy = 0;
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        // R1
        chk(out_data == 0, "R1", longint'(out_data), 0);
        chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
        chk(in_ready == 1'b0, "R1", longint'(in_ready), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // ratio 128, tick every cycle; select moved mid-run must be ignored (R3)
        repeat (2) step(0, 0, 0, 0, 2'b00);
        run(128 * 3, 1, 2'b00, 0, 1000);
        run(128 * 5, 1, 2'b10, 0, 1000);
        dc_chk(1000);

        // ratio 125, ticks every other cycle, negative level
        repeat (3) step(0, 0, 0, 0, 2'b01);
        run(125 * 7, 2, 2'b01, 0, -20000);
        dc_chk(-20000);

        // ratio 136, gapped ticks, varying data with dropped samples
        repeat (2) step(0, 0, 0, 0, 2'b10);
        run(136 * 8, 3, 2'b10, 1, 3000);

        // spare select code, full-scale levels
        repeat (2) step(0, 0, 0, 0, 2'b11);
        run(128 * 6, 1, 2'b11, 0, 32767);
        dc_chk(32767);
        run(128 * 6, 1, 2'b11, 0, -32768);
        dc_chk(-32768);

        // disable in the middle of a sample period, then restart clean (R7)
        repeat (2) step(0, 0, 0, 0, 2'b01);
        run(125 * 3 + 50, 1, 2'b01, 1, -7000);
        repeat (2) step(0, 0, 0, 0, 2'b00);
        run(128 * 3, 1, 2'b00, 1, 500);

        repeat (2) step(1, 0, 0, 0, 2'b00);
        chk(exp_q.size() == 0, "R8", exp_q.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule